// File: doc/BRIEF.md
# Even/Odd Banked Tag Store with Word Mode

This block is the tag storage for one way of a set-associative cache whose tag is between 16 and 31 bits wide. The sets of the way are split over two banks: sets with an even index live in the even bank and sets with an odd index in the odd bank. Both banks are addressed by the index with its least significant bit dropped. Each bank therefore has half as many rows as the way has sets.

In cache mode one tag is written to, or read from, the single bank that the index LSB selects. In word mode the way serves as scratch-pad storage. A 32-bit word is split into two 16-bit halves, and both halves go to the same row of both banks in the same cycle. The even bank takes the upper half and the odd bank takes the lower half. A word-mode read joins the two halves again, so a narrow tag array still gives single-cycle 32-bit access. Tag comparison is done outside this block.

Requests arrive on a valid/ready channel. Read results leave on a valid/ready channel one cycle after the read is accepted. The request channel is ready whenever no response is waiting, or whenever the waiting response is taken in the same cycle. While a response is held back, no request is accepted and the response is held stable. Writes produce no response.

Top module: `tsb_tag_way`

## Requirements
- R1: A cache-mode write (req_spm=0) stores req_tag only in the bank selected by req_index[0] (0 = even, 1 = odd), at row req_index>>1; the other set of the pair keeps its tag.
- R2: A cache-mode read returns, on rsp_tag, the tag stored for req_index, with rsp_valid high in the cycle after acceptance; rsp_word is 0 for such a response.
- R3: A word-mode write (req_spm=1) stores req_wdata[31:16] in the even bank and req_wdata[15:0] in the odd bank, both at row req_index>>1 in the same cycle; req_index[0] is ignored.
- R4: A word-mode read returns rsp_word = {even[15:0], odd[15:0]} from row req_index>>1 in the cycle after acceptance, ignoring req_index[0]; rsp_tag is 0 for such a response.
- R5: Halves are stored zero-extended to the tag width: after a word-mode write, a cache read of set 2k gives the upper half zero-extended and set 2k+1 gives the lower half; a word read of a pair written in cache mode gives the low 16 bits of each tag.
- R6: req_ready = !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_tag and rsp_word stay stable and no request is accepted.
- R7: An accepted write never raises rsp_valid in the next cycle.
- R8: Out of reset rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spm | input | 1 | 1 = 32-bit word mode, 0 = cache tag mode |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Tag to write in cache mode |
| req_wdata | input | 32 | Word to write in word mode |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_tag | output | TAG_W | Tag read in cache mode, 0 in word mode |
| rsp_word | output | 32 | Word read in word mode, 0 in cache mode |

## Verification
On every cycle the assertions check the bank write enables: exactly one bank, the one named by the index LSB, in cache mode, and both banks with the correct halves in word mode. They also check the stability of a held response, the one-cycle read latency, and that writes stay silent on the response channel. The stored contents are visible only through the bench's scenarios. These cover the survival of the neighbouring set after a cache write, the aliasing between word and tag views of one set pair, the ignored index LSB in word mode, and the fact that a request offered during a stall leaves the memory untouched. Each of these is compared with a bench model of both banks.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic { MODE_CACHE = 1'b0, MODE_SPM = 1'b1 } tsb_mode_e;

  // Captured at read acceptance, steers the response mux one cycle later.
  typedef struct packed {
    tsb_mode_e mode;
    logic      odd;
  } tsb_rsel_t;
endpackage

// File: rtl/tsb_bank.sv
module tsb_bank #(
  parameter int ROWS  = 32,
  parameter int W     = 20,
  parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [ROWS];

  // Storage array is not reset, like a RAM macro; read data is registered
  // and holds its value until the next read enable.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  AST_BANK_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R1
endmodule

// File: rtl/tsb_steer.sv
module tsb_steer
  import tsb_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              write,
  input  logic              spm,
  input  logic              lsb,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WORD_W-1:0] wdata,
  output logic              we_even,
  output logic              we_odd,
  output logic              re_even,
  output logic              re_odd,
  output logic [TAG_W-1:0]  wd_even,
  output logic [TAG_W-1:0]  wd_odd
);
  logic [TAG_W-1:0] hi_ext, lo_ext;

  always_comb begin
    hi_ext = '0;
    lo_ext = '0;
    hi_ext[HALF_W-1:0] = wdata[WORD_W-1:HALF_W];
    lo_ext[HALF_W-1:0] = wdata[HALF_W-1:0];
  end

  always_comb begin
    if (spm) begin
      wd_even = hi_ext;
      wd_odd  = lo_ext;
      we_even = acc && write;
      we_odd  = acc && write;
      re_even = acc && !write;
      re_odd  = acc && !write;
    end else begin
      wd_even = tag;
      wd_odd  = tag;
      we_even = acc && write && !lsb;
      we_odd  = acc && write && lsb;
      re_even = acc && !write && !lsb;
      re_odd  = acc && !write && lsb;
    end
  end

  AST_CACHE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && write && !spm) |-> ((we_even != we_odd) && (we_odd == lsb))); // R1
  AST_SPM_BOTH_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && write && spm) |-> (we_even && we_odd
      && (wd_even[HALF_W-1:0] == wdata[WORD_W-1:HALF_W])
      && (wd_odd[HALF_W-1:0] == wdata[HALF_W-1:0]))); // R3
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && write) |-> (!we_even && !we_odd)); // R1
endmodule

// File: rtl/tsb_rdmux.sv
module tsb_rdmux
  import tsb_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  tsb_rsel_t         sel,
  input  logic [TAG_W-1:0]  even_q,
  input  logic [TAG_W-1:0]  odd_q,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    tag_o  = '0;
    word_o = '0;
    if (sel.mode == MODE_SPM) word_o = {even_q[HALF_W-1:0], odd_q[HALF_W-1:0]};
    else                      tag_o  = sel.odd ? odd_q : even_q;
  end
endmodule

// File: rtl/tsb_tag_way.sv
module tsb_tag_way
  import tsb_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,  // 16..31
  localparam int IDX_W = $clog2(SETS),
  localparam int ROWS  = SETS / 2,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_spm,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [WORD_W-1:0] rsp_word
);
  logic             acc;
  logic             rsp_valid_q;
  tsb_rsel_t        sel_q;
  logic [1:0]       bank_we, bank_re;
  logic [TAG_W-1:0] bank_wd [2];
  logic [TAG_W-1:0] bank_rd [2];
  logic [ROW_W-1:0] row;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign row       = ROW_W'(req_index >> 1);

  tsb_steer #(.TAG_W(TAG_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .acc(acc), .write(req_write), .spm(req_spm),
    .lsb(req_index[0]), .tag(req_tag), .wdata(req_wdata),
    .we_even(bank_we[0]), .we_odd(bank_we[1]),
    .re_even(bank_re[0]), .re_odd(bank_re[1]),
    .wd_even(bank_wd[0]), .wd_odd(bank_wd[1])
  );

  // Bank 0 holds even sets, bank 1 holds odd sets.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    tsb_bank #(.ROWS(ROWS), .W(TAG_W), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .re(bank_re[b]),
      .addr(row), .wdata(bank_wd[b]), .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      sel_q       <= '{mode: MODE_CACHE, odd: 1'b0};
    end else if (acc && !req_write) begin
      rsp_valid_q <= 1'b1;
      sel_q       <= '{mode: tsb_mode_e'(req_spm), odd: req_index[0]};
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;

  tsb_rdmux #(.TAG_W(TAG_W)) u_rdmux (
    .sel(sel_q), .even_q(bank_rd[0]), .odd_q(bank_rd[1]),
    .tag_o(rsp_tag), .word_o(rsp_word)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_word))); // R6
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R2
  AST_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid); // R7
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (bank_we == 2'b00)); // R6
endmodule

// File: tb/tb_tsb_tag_way.sv
`timescale 1ns/1ps
module tb_tsb_tag_way;
  localparam int SETS = 64;
  localparam int TAG_W = 20;
  localparam int IDX_W = $clog2(SETS);
  localparam int ROWS = SETS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_spm = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [IDX_W-1:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0, rsp_tag;
  logic [31:0] req_wdata = '0, rsp_word;

  int checks = 0, errors = 0, cyc = 0;
  logic [TAG_W-1:0] m_even [ROWS];
  logic [TAG_W-1:0] m_odd [ROWS];

  always #4 clk = ~clk;

  tsb_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_spm(req_spm), .req_index(req_index),
    .req_tag(req_tag), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_word(rsp_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] zx16(input logic [15:0] h);
    logic [TAG_W-1:0] r = '0;
    r[15:0] = h;
    return r;
  endfunction

  function automatic logic [31:0] exp_tag(input logic [IDX_W-1:0] idx);
    return 32'(idx[0] ? m_odd[idx >> 1] : m_even[idx >> 1]);
  endfunction

  function automatic logic [31:0] exp_word(input logic [IDX_W-1:0] idx);
    return {m_even[idx >> 1][15:0], m_odd[idx >> 1][15:0]};
  endfunction

  task automatic do_write(input logic spm, input logic [IDX_W-1:0] idx,
                          input logic [TAG_W-1:0] tag, input logic [31:0] wd);
    req_valid = 1; req_write = 1; req_spm = spm; req_index = idx;
    req_tag = tag; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (spm) begin
      m_even[idx >> 1] = zx16(wd[31:16]);
      m_odd[idx >> 1]  = zx16(wd[15:0]);
    end else if (idx[0]) m_odd[idx >> 1] = tag;
    else                 m_even[idx >> 1] = tag;
    chk("R7 write raises no response", 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_read(input logic spm, input logic [IDX_W-1:0] idx, input string req);
    req_valid = 1; req_write = 0; req_spm = spm; req_index = idx;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R2 read response valid after one cycle", 32'(rsp_valid), 32'd1);
    if (spm) begin
      chk(req, rsp_word, exp_word(idx));
      chk("R4 rsp_tag zero in word mode", 32'(rsp_tag), 32'd0);
    end else begin
      chk(req, 32'(rsp_tag), exp_tag(idx));
      chk("R2 rsp_word zero in cache mode", rsp_word, 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] held_tag;
    logic [31:0] held_word;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk("R8 rsp_valid low in reset", 32'(rsp_valid), 32'd0);
    chk("R8 req_ready high in reset", 32'(req_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R8 rsp_valid low after reset", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < SETS; i++)
      do_write(0, IDX_W'(i), TAG_W'(i * 32'h9E37 + 32'h15), 32'h0);
    for (int i = 0; i < 4; i++) do_read(0, IDX_W'(i), "R2 cache read after init");

    // R1: writing set 6 leaves set 7 alone, and vice versa
    do_write(0, 6, 20'hA5A5A, 32'h0);
    do_read(0, 7, "R1 neighbour odd set untouched");
    do_read(0, 6, "R1 written even set");
    do_write(0, 13, 20'h3C3C3, 32'h0);
    do_read(0, 12, "R1 neighbour even set untouched");
    do_read(0, 13, "R1 written odd set");

    // R3/R4: word write at odd index, read via even index
    do_write(1, 9, '0, 32'hDEADBEEF);
    do_read(1, 8, "R4 word read ignores index LSB");
    chk("R3 word halves placed", rsp_word, 32'hDEADBEEF);
    do_read(0, 8, "R5 even set shows upper half");
    chk("R5 upper half zero-extended", 32'(rsp_tag), 32'h0000DEAD);
    do_read(0, 9, "R5 odd set shows lower half");
    chk("R5 lower half zero-extended", 32'(rsp_tag), 32'h0000BEEF);

    // R5: cache tags seen as a word
    do_write(0, 20, 20'hFFFFF, 32'h0);
    do_write(0, 21, 20'hABCDE, 32'h0);
    do_read(1, 21, "R5 word view of cache tags");
    chk("R5 low 16 bits of each tag", rsp_word, 32'hFFFFBCDE);

    // R6: back-pressure
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_spm = 0; req_index = 6;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R6 response valid under stall", 32'(rsp_valid), 32'd1);
    held_tag = rsp_tag; held_word = rsp_word;
    req_valid = 1; req_write = 1; req_spm = 0; req_index = 6; req_tag = 20'h11111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 req_ready low during stall", 32'(req_ready), 32'd0);
      chk("R6 rsp_valid held", 32'(rsp_valid), 32'd1);
      chk("R6 rsp_tag stable", 32'(rsp_tag), 32'(held_tag));
      chk("R6 rsp_word stable", rsp_word, held_word);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk("R6 response consumed", 32'(rsp_valid), 32'd0);
    do_read(0, 6, "R6 write offered during stall not stored");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [IDX_W-1:0] idx;
      logic wr, sp;
      idx = IDX_W'($urandom % SETS);
      wr = $urandom % 2;
      sp = $urandom % 2;
      if (wr) do_write(sp, idx, TAG_W'($urandom), $urandom);
      else    do_read(sp, idx, sp ? "R4 random word read" : "R2 random cache read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule